// File: doc/BRIEF.md
# Processor Status Flag Register

This block holds the eight-bit status byte of a small eight-bit CPU: carry, zero, interrupt mask, decimal mode, break marker, a spare bit and signed overflow and sign. On each clock the control unit presents one operation class, together with the datapath values that class needs. The block changes only the flags that belong to that class and leaves every other flag as it was.

A separate input lets external hardware force the overflow flag high. It is synchronised inside the block, and a rising edge sets overflow. The packed byte is always visible on one output, so it can be pushed to the stack or tested by branch logic. Decimal correction, result generation, branch evaluation and instruction decode stay outside.

Top module: `cpu_status_reg`

## Requirements
- R1: A synchronous active-low reset loads the byte 0x24: mask (bit 2) and spare bit (bit 5) set, all other flags cleared. Bit positions are carry 0, zero 1, mask 2, decimal 3, break 4, spare 5, overflow 6, sign 7.
- R2: Class 1 (arithmetic) sets carry to `carry_out`, zero to 1 exactly when `result` is 0, and sign to bit 7 of `result`.
- R3: Class 1 sets overflow when both operands have the same bit 7 and the result's bit 7 differs from it. Otherwise it clears overflow, so operands of opposite sign never set it.
- R4: Class 2 (shift or compare) updates carry, zero and sign as in R2 and leaves overflow, mask, decimal and break unchanged.
- R5: Class 3 (move or logic) updates only zero and sign from `result`.
- R6: Class 4 (bit test) sets zero when `opnd_a & opnd_b` is 0, sign to bit 7 of `opnd_b` and overflow to bit 6 of `opnd_b`.
- R7: Class 5 (flag command) writes `flag_val` into the flag picked by `flag_sel` (0 carry, 1 mask, 2 decimal, 3 overflow). The combination of select 3 with value 1 has no effect, because overflow can only be cleared by command.
- R8: Class 6 (pull) loads bits 7, 6, 3, 2, 1 and 0 from `pull_data`. The break bit keeps its value and the spare bit stays 1.
- R9: Class 7 (interrupt or break entry) sets the mask and loads the break bit from `brk_src`. No other class changes the break bit.
- R10: The spare bit 5 reads 1 at all times after reset.
- R11: `set_ovf` passes through a two-flop synchroniser. Its rising edge sets overflow at the third rising clock edge after the input rises. When this coincides with an operation that writes overflow, the external set wins. A level held high sets overflow only once.
- R12: Class 0 (hold) leaves the byte unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_class | input | 3 | Operation class for this cycle (0..7) |
| result | input | 8 | Result byte from the datapath |
| opnd_a | input | 8 | First operand (accumulator on bit test) |
| opnd_b | input | 8 | Second operand (memory byte on bit test) |
| carry_out | input | 1 | Carry or shifted-out bit from the datapath |
| flag_sel | input | 2 | Flag picked by a flag command |
| flag_val | input | 1 | Value written by a flag command |
| pull_data | input | 8 | Status byte pulled from the stack |
| brk_src | input | 1 | 1 when entry is a software break |
| set_ovf | input | 1 | Asynchronous external overflow set |
| status | output | 8 | Packed status byte |

## Verification
Every flag is visible on `status` one edge after the operation that writes it. A wrong update, or a flag that fails to hold, therefore shows up on the next clock. A corrupted flag then persists until an operation of a class that owns that flag overwrites it. Because of this, the bench compares the whole byte against its model on every cycle, across long runs of random mixed classes. A fault in the synchroniser shows up as overflow rising one edge too early or too late, or as overflow being set again while the input is held high. The external-set checks are therefore placed against operations that clear overflow in the same cycle.

// File: rtl/psr_pkg.sv
// Package: shared encodings for the processor status register.
// Assumes an eight-bit status byte with fixed flag positions.
package psr_pkg;

    typedef enum logic [2:0] {
        OPC_HOLD  = 3'd0,
        OPC_ARITH = 3'd1,
        OPC_NZC   = 3'd2,
        OPC_MOVE  = 3'd3,
        OPC_BITT  = 3'd4,
        OPC_FLAG  = 3'd5,
        OPC_PULL  = 3'd6,
        OPC_ENTRY = 3'd7
    } op_class_e;

    typedef enum logic [1:0] {
        FS_CARRY = 2'd0,
        FS_MASK  = 2'd1,
        FS_DEC   = 2'd2,
        FS_OVF   = 2'd3
    } flag_sel_e;

    localparam int unsigned PSR_W = 8;

    typedef struct packed {
        logic sgn;   // bit 7
        logic ovf;   // bit 6
        logic spare; // bit 5
        logic brk;   // bit 4
        logic dec;   // bit 3
        logic mask;  // bit 2
        logic zero;  // bit 1
        logic cry;   // bit 0
    } psr_t;

    localparam psr_t PSR_RESET = psr_t'(8'h24);

endpackage

// File: rtl/psr_sync.sv
// Module: psr_sync
// Synchronises an asynchronous level through STAGES flops and emits a
// one-cycle pulse on each rising edge of the synchronised level.
// Assumes STAGES >= 2; reset is synchronous, active low.
module psr_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0] chain;
    logic              seen;

    // Shift the input through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= async_in;
    end

    genvar g;
    generate
        for (g = 1; g < STAGES; g++) begin : g_stage
            // One synchroniser stage.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= 1'b0;
                else        chain[g] <= chain[g-1];
            end
        end
    endgenerate

    // Remember the previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= chain[LAST];
    end

    // Pulse when the synchronised level goes from 0 to 1.
    always_comb rise = chain[LAST] & ~seen;

endmodule

// File: rtl/psr_next.sv
// Module: psr_next
// Combinational next-state logic of the status byte. Only the flags owned
// by the presented operation class change. The external overflow set
// overrides any overflow written by the same operation.
// Assumes DATA_W >= 2 (bit test reads the two top operand bits).
module psr_next
    import psr_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  psr_t              cur,
    input  op_class_e         op,
    input  logic [DATA_W-1:0] result,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic              carry_out,
    input  flag_sel_e         sel,
    input  logic              val,
    input  psr_t              pulled,
    input  logic              brk_src,
    input  logic              ext_set,
    output psr_t              nxt
);
    localparam int unsigned MSB = DATA_W - 1;
    localparam int unsigned SUB = DATA_W - 2;

    logic res_zero;
    logic res_sign;
    logic add_ovf;
    logic and_zero;

    // Common result-derived terms.
    always_comb begin
        res_zero = ~|result;
        res_sign = result[MSB];
        add_ovf  = (opnd_a[MSB] == opnd_b[MSB]) && (result[MSB] != opnd_a[MSB]);
        and_zero = ~|(opnd_a & opnd_b);
    end

    // Select which flags the operation class writes.
    always_comb begin
        nxt = cur;
        case (op)
            OPC_ARITH: begin
                nxt.cry  = carry_out;
                nxt.zero = res_zero;
                nxt.sgn  = res_sign;
                nxt.ovf  = add_ovf;
            end
            OPC_NZC: begin
                nxt.cry  = carry_out;
                nxt.zero = res_zero;
                nxt.sgn  = res_sign;
            end
            OPC_MOVE: begin
                nxt.zero = res_zero;
                nxt.sgn  = res_sign;
            end
            OPC_BITT: begin
                nxt.zero = and_zero;
                nxt.sgn  = opnd_b[MSB];
                nxt.ovf  = opnd_b[SUB];
            end
            OPC_FLAG: begin
                case (sel)
                    FS_CARRY: nxt.cry  = val;
                    FS_MASK:  nxt.mask = val;
                    FS_DEC:   nxt.dec  = val;
                    FS_OVF:   if (!val) nxt.ovf = 1'b0;
                    default:  nxt = cur;
                endcase
            end
            OPC_PULL: begin
                nxt.sgn  = pulled.sgn;
                nxt.ovf  = pulled.ovf;
                nxt.dec  = pulled.dec;
                nxt.mask = pulled.mask;
                nxt.zero = pulled.zero;
                nxt.cry  = pulled.cry;
            end
            OPC_ENTRY: begin
                nxt.mask = 1'b1;
                nxt.brk  = brk_src;
            end
            default: nxt = cur;
        endcase
        if (ext_set) nxt.ovf = 1'b1;
        nxt.spare = 1'b1;
    end

endmodule

// File: rtl/cpu_status_reg.sv
// Module: cpu_status_reg (top)
// Eight-bit processor status register with per-class flag updates, an
// external synchronised overflow set and a packed byte output.
// Assumes the control unit presents exactly one class per cycle.
module cpu_status_reg
    import psr_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        op_class,
    input  logic [DATA_W-1:0] result,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic              carry_out,
    input  logic [1:0]        flag_sel,
    input  logic              flag_val,
    input  logic [PSR_W-1:0]  pull_data,
    input  logic              brk_src,
    input  logic              set_ovf,
    output logic [PSR_W-1:0]  status
);
    psr_t psr_q;
    psr_t psr_d;
    logic so_rise;

    psr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (set_ovf),
        .rise     (so_rise)
    );

    psr_next #(.DATA_W(DATA_W)) u_next (
        .cur       (psr_q),
        .op        (op_class_e'(op_class)),
        .result    (result),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .carry_out (carry_out),
        .sel       (flag_sel_e'(flag_sel)),
        .val       (flag_val),
        .pulled    (psr_t'(pull_data)),
        .brk_src   (brk_src),
        .ext_set   (so_rise),
        .nxt       (psr_d)
    );

    // Status register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) psr_q <= PSR_RESET;
        else        psr_q <= psr_d;
    end

    // Present the packed byte.
    always_comb status = psr_q;

endmodule

// File: rtl/psr_checks.sv
// Module: psr_checks
// Property checker for cpu_status_reg, attached by bind below.
module psr_checks (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] op_class,
    input logic [7:0] opnd_b,
    input logic [1:0] flag_sel,
    input logic       flag_val,
    input logic       brk_src,
    input logic       so_rise,
    input logic [7:0] status
);
    p_spare_one_r10: assert property (@(posedge clk) disable iff (!rst_n)
        status[5]);

    p_entry_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_class == 3'd7) |=> (status[2] && status[4] == $past(brk_src)));

    p_break_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_class != 3'd7) |=> $stable(status[4]));

    p_bit6_ovf_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_class == 3'd4 && !so_rise) |=> (status[6] == $past(opnd_b[6])));

    p_ext_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        so_rise |=> status[6]);

    p_no_set_ovf_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_class == 3'd5 && flag_sel == 2'd3 && flag_val && !so_rise)
        |=> $stable(status[6]));

    p_move_keeps_cv_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_class == 3'd3 && !so_rise) |=> ($stable(status[0]) && $stable(status[6])));

    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (op_class == 3'd0 && !so_rise) |=> $stable(status));

endmodule

bind cpu_status_reg psr_checks u_psr_checks (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_class (op_class),
    .opnd_b   (opnd_b),
    .flag_sel (flag_sel),
    .flag_val (flag_val),
    .brk_src  (brk_src),
    .so_rise  (so_rise),
    .status   (status)
);

// File: tb/cpu_status_reg_test.sv
// Bench: drives classes on the falling edge, keeps a behavioural flag model
// updated on the rising edge and compares the whole byte every cycle.
module cpu_status_reg_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] op_class = 3'd0;
    logic [7:0] result = 8'h00, opnd_a = 8'h00, opnd_b = 8'h00, pull_data = 8'h00;
    logic       carry_out = 1'b0, flag_val = 1'b0, brk_src = 1'b0, set_ovf = 1'b0;
    logic [1:0] flag_sel = 2'd0;
    logic [7:0] status;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    bit armed  = 1'b0;
    string cur_req = "R1";
    string edge_req = "R1";

    logic [7:0] exp_st;
    logic [2:0] so_hist;   // sampled set_ovf history, newest in bit 0

    always #10 clk = ~clk;   // 50 MHz

    cpu_status_reg uut (
        .clk(clk), .rst_n(rst_n), .op_class(op_class), .result(result),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .carry_out(carry_out),
        .flag_sel(flag_sel), .flag_val(flag_val), .pull_data(pull_data),
        .brk_src(brk_src), .set_ovf(set_ovf), .status(status)
    );

    // Behavioural flag model.
    always @(posedge clk) begin : model
        logic [7:0] n;
        int sa, sb, sr;
        n = exp_st;
        edge_req <= cur_req;
        armed <= 1'b1;
        if (!rst_n) begin
            exp_st  <= 8'h24;
            so_hist <= 3'b000;
        end else begin
            sa = $signed(opnd_a); sb = $signed(opnd_b); sr = $signed(result);
            case (op_class)
                3'd1: begin
                    n[0] = carry_out; n[1] = (result == 0); n[7] = (sr < 0);
                    n[6] = ((sa < 0) == (sb < 0)) && ((sr < 0) != (sa < 0));
                end
                3'd2: begin n[0] = carry_out; n[1] = (result == 0); n[7] = (sr < 0); end
                3'd3: begin n[1] = (result == 0); n[7] = (sr < 0); end
                3'd4: begin n[1] = ((opnd_a & opnd_b) == 0); n[7] = opnd_b[7]; n[6] = opnd_b[6]; end
                3'd5: begin
                    if (flag_sel == 0) n[0] = flag_val;
                    else if (flag_sel == 1) n[2] = flag_val;
                    else if (flag_sel == 2) n[3] = flag_val;
                    else if (!flag_val) n[6] = 1'b0;
                end
                3'd6: n = {pull_data[7:6], 1'b1, exp_st[4], pull_data[3:0]};
                3'd7: begin n[2] = 1'b1; n[4] = brk_src; end
                default: ;
            endcase
            // external set: input high two samples ago, low three samples ago
            if (so_hist[1] && !so_hist[2]) n[6] = 1'b1;
            n[5] = 1'b1;
            exp_st  <= n;
            so_hist <= {so_hist[1:0], set_ovf};
        end
    end

    // Compare every cycle, away from the active edge.
    always @(negedge clk) begin
        if (armed && !done) begin
            checks++;
            if (status !== exp_st) begin
                fails++;
                $display("FAIL %s: status=%02h expected=%02h at %0t", edge_req, status, exp_st, $time);
            end
        end
    end

    task automatic drive(input string rq, input logic [2:0] op, input logic [7:0] r,
                         input logic [7:0] a, input logic [7:0] b, input logic co,
                         input logic [1:0] sel, input logic v, input logic [7:0] pd,
                         input logic bk);
        @(negedge clk);
        cur_req = rq; op_class = op; result = r; opnd_a = a; opnd_b = b;
        carry_out = co; flag_sel = sel; flag_val = v; pull_data = pd; brk_src = bk;
    endtask

    task automatic arith(input string rq, input logic [7:0] a, input logic [7:0] b, input logic ci);
        logic [8:0] s;
        s = {1'b0, a} + {1'b0, b} + {8'b0, ci};
        drive(rq, 3'd1, s[7:0], a, b, s[8], 2'd0, 1'b0, 8'h00, 1'b0);
    endtask

    task automatic flagcmd(input string rq, input logic [1:0] sel, input logic v);
        drive(rq, 3'd5, 8'h00, 8'h00, 8'h00, 1'b0, sel, v, 8'h00, 1'b0);
    endtask

    task automatic hold(input string rq, input int n);
        for (int k = 0; k < n; k++)
            drive(rq, 3'd0, 8'($urandom), 8'($urandom), 8'($urandom), 1'($urandom),
                  2'($urandom), 1'($urandom), 8'($urandom), 1'($urandom));
    endtask

    // Watchdog: an overrun counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        cur_req = "R1";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        hold("R12", 3);
        // arithmetic: flags and signed overflow
        arith("R2", 8'h50, 8'h50, 1'b0);   // A0: N=1 V=1 C=0
        arith("R3", 8'hD0, 8'h90, 1'b0);   // 60: C=1 V=1
        arith("R2", 8'h80, 8'h80, 1'b0);   // 00: Z=1 C=1 V=1
        arith("R3", 8'h05, 8'hFB, 1'b0);   // 00: opposite signs, V=0
        arith("R3", 8'h7F, 8'h00, 1'b1);   // 80: V=1
        // shift/compare class keeps V
        drive("R4", 3'd2, 8'h80, 8'h00, 8'h00, 1'b1, 2'd0, 1'b0, 8'h00, 1'b0);
        drive("R4", 3'd2, 8'h00, 8'hFF, 8'hFF, 1'b0, 2'd0, 1'b0, 8'h00, 1'b0);
        // moves
        drive("R5", 3'd3, 8'h00, 8'h00, 8'h00, 1'b1, 2'd0, 1'b0, 8'h00, 1'b0);
        drive("R5", 3'd3, 8'h7F, 8'h80, 8'h80, 1'b1, 2'd0, 1'b0, 8'h00, 1'b0);
        drive("R5", 3'd3, 8'hFF, 8'h00, 8'h00, 1'b0, 2'd0, 1'b0, 8'h00, 1'b0);
        // bit test
        drive("R6", 3'd4, 8'hFF, 8'h0F, 8'hC0, 1'b1, 2'd0, 1'b0, 8'h00, 1'b0);
        drive("R6", 3'd4, 8'h00, 8'hFF, 8'h01, 1'b1, 2'd0, 1'b0, 8'h00, 1'b0);
        drive("R6", 3'd4, 8'h00, 8'h40, 8'h40, 1'b0, 2'd0, 1'b0, 8'h00, 1'b0);
        // flag commands
        flagcmd("R7", 2'd0, 1'b1); flagcmd("R7", 2'd0, 1'b0);
        flagcmd("R7", 2'd1, 1'b0); flagcmd("R7", 2'd1, 1'b1);
        flagcmd("R7", 2'd2, 1'b1); flagcmd("R7", 2'd2, 1'b0);
        flagcmd("R7", 2'd3, 1'b0); flagcmd("R7", 2'd3, 1'b1);  // set V has no effect
        arith("R7", 8'h40, 8'h40, 1'b0);
        flagcmd("R7", 2'd3, 1'b0);
        // pull and entry
        drive("R8", 3'd6, 8'h00, 8'h00, 8'h00, 1'b0, 2'd0, 1'b0, 8'hFF, 1'b1);
        drive("R8", 3'd6, 8'h00, 8'h00, 8'h00, 1'b0, 2'd0, 1'b0, 8'h00, 1'b1);
        drive("R9", 3'd7, 8'h00, 8'h00, 8'h00, 1'b0, 2'd0, 1'b0, 8'h00, 1'b1);
        drive("R9", 3'd6, 8'h00, 8'h00, 8'h00, 1'b0, 2'd0, 1'b0, 8'h00, 1'b0);
        drive("R9", 3'd7, 8'h00, 8'h00, 8'h00, 1'b0, 2'd0, 1'b0, 8'h00, 1'b0);
        hold("R10", 2);
        // external overflow set, latency and priority
        flagcmd("R11", 2'd3, 1'b0);
        set_ovf = 1'b1;
        for (int k = 0; k < 4; k++) flagcmd("R11", 2'd3, 1'b0);  // edge lands on a clear
        hold("R11", 2);
        flagcmd("R11", 2'd3, 1'b0);
        hold("R11", 3);                                          // held high: stays clear
        set_ovf = 1'b0;
        hold("R11", 3);
        set_ovf = 1'b1;
        for (int k = 0; k < 4; k++) arith("R11", 8'h01, 8'h01, 1'b0);
        set_ovf = 1'b0;
        // random mix
        for (int k = 0; k < 400; k++) begin
            drive("R12", 3'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), 1'($urandom),
                  2'($urandom), 1'($urandom), 8'($urandom), 1'($urandom));
            if (($urandom % 7) == 0) set_ovf = ~set_ovf;
        end
        // reset again mid-run
        @(negedge clk); cur_req = "R1"; rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        hold("R12", 3);
        @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule